// File: doc/BRIEF.md
# Second Operand Shifter and Immediate Expander

This block builds the 32-bit second operand that a data-processing ALU consumes, together with the shifter carry that flag-setting operations may use. It receives the immediate-select bit of the instruction, the 12-bit second-operand field, the already-read values of the two source registers involved (the register being shifted and the register holding a dynamic shift amount), and the current carry flag.

With the immediate bit set, an 8-bit constant is rotated right by twice a 4-bit rotate count. This reaches many wide constants, such as 0xFF0, with only twelve encoding bits. With the immediate bit clear, the register value is shifted left, shifted right logically or arithmetically, or rotated right. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register. The result and carry are registered, so they appear one clock after the inputs are presented.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst_n` is low both outputs are 0; otherwise `operandOut` and `carryOut` show the result for the inputs sampled at the previous rising clock edge.
- R2: When `immSel` is 1 the operand is `src2Field[7:0]` zero-extended to 32 bits and rotated right by 2 × `src2Field[11:8]` (rotate field 14 with constant 0xFF yields 0xFF0).
- R3: In immediate form the carry-out is bit 31 of the rotated result when the rotate field is nonzero, and equals `carryIn` when it is zero.
- R4: When `immSel` is 0 the shift kind is `src2Field[6:5]` (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right). When `src2Field[4]` is 0 the amount is `src2Field[11:7]`; when it is 1 the amount is `rsValue[7:0]`. `src2Field[3:0]` has no effect on the outputs.
- R5: A left logical shift by n in 1..31 gives `rmValue << n` with carry `rmValue[32-n]`.
- R6: A right logical or arithmetic shift by n in 1..31 gives the shifted value (arithmetic copies bit 31 into the vacated bits) with carry `rmValue[n-1]`.
- R7: A rotate right by an amount whose low 5 bits m are nonzero rotates by m, with carry equal to bit 31 of the result. A nonzero multiple of 32 leaves the value unchanged, with carry `rmValue[31]`.
- R8: A shift amount of 0, for any kind, passes `rmValue` unchanged and the carry-out equals `carryIn`.
- R9: For an amount of exactly 32, the left shift gives 0 with carry `rmValue[0]` and the right logical shift gives 0 with carry `rmValue[31]`. Above 32, both give 0 with carry 0.
- R10: A right arithmetic shift by 32 or more gives 32 copies of `rmValue[31]`, with that bit as carry.
- R11: `rsValue[31:8]` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| immSel | input | 1 | 1 selects the rotated-immediate form |
| src2Field | input | 12 | Second-operand field of the instruction |
| rmValue | input | 32 | Value of the register being shifted |
| rsValue | input | 32 | Value of the register giving a dynamic shift amount |
| carryIn | input | 1 | Current carry flag |
| operandOut | output | 32 | Registered second operand |
| carryOut | output | 1 | Registered shifter carry-out |

## Verification
A register-specified amount can select the zero-amount pass-through and the out-of-range saturation in the same kind of operation. Within one instruction, the amount source (field or register byte) and the boundary handling interact. The bench drives register amounts of 0, 32, 33, 255 and multiples of 32, with junk in the upper bits of `rsValue`, mixed into a long stream of seeded random instructions. Each result is compared with a bench model that shifts one bit per step and tracks the last bit shifted out. That model needs no special case for any boundary.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;
  localparam int OpW    = 32;
  localparam int FieldW = 12;
  localparam int AmtW   = 8;
  localparam int ImmW   = 8;
  localparam int RotW   = 4;
  localparam int ShW    = $clog2(OpW);

  typedef enum logic [1:0] {
    KIND_SHL = 2'b00,
    KIND_SHR = 2'b01,
    KIND_SAR = 2'b10,
    KIND_ROT = 2'b11
  } shiftKind_t;

  typedef struct packed {
    logic            useImm;
    shiftKind_t      kind;
    logic [AmtW-1:0] amount;
    logic            isZero;
    logic            isExact;
    logic            isOver;
  } shiftStrobes_t;
endpackage

// File: rtl/opnd_shifter_ctrl.sv
module opnd_shifter_ctrl
  import opnd_shifter_pkg::*;
(
  input  logic              immSel,
  input  logic [FieldW-1:0] src2Field,
  input  logic [AmtW-1:0]   rsLowByte,
  output shiftStrobes_t     strb
);
  logic [AmtW-1:0] amt;

  always_comb begin
    if (immSel) begin
      amt = AmtW'({src2Field[FieldW-1 -: RotW], 1'b0});
    end else if (src2Field[4]) begin
      amt = rsLowByte;
    end else begin
      amt = AmtW'(src2Field[FieldW-1 -: ShW]);
    end
  end

  always_comb begin
    strb.useImm  = immSel;
    strb.kind    = immSel ? KIND_ROT : shiftKind_t'(src2Field[6:5]);
    strb.amount  = amt;
    strb.isZero  = (amt == '0);
    strb.isExact = (amt == AmtW'(OpW));
    strb.isOver  = (amt > AmtW'(OpW));
  end
endmodule

// File: rtl/opnd_shifter_dp.sv
module opnd_shifter_dp
  import opnd_shifter_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  shiftStrobes_t   strb,
  input  logic [ImmW-1:0] imm8,
  input  logic [OpW-1:0]  rmValue,
  input  logic            carryIn,
  output logic [OpW-1:0]  operandOut,
  output logic            carryOut
);
  logic [OpW-1:0]        srcVal;
  logic [ShW-1:0]        n5;
  logic [OpW:0]          shlWide;
  logic [OpW:0]          shrWide;
  logic signed [OpW:0]   sarWide;
  logic [OpW-1:0]        rotVal;
  logic [OpW-1:0]        resNext;
  logic                  carryNext;
  logic                  primed;

  assign srcVal  = strb.useImm ? {{(OpW-ImmW){1'b0}}, imm8} : rmValue;
  assign n5      = strb.amount[ShW-1:0];
  assign shlWide = {1'b0, srcVal} << n5;
  assign shrWide = {srcVal, 1'b0} >> n5;
  assign sarWide = $signed({srcVal, 1'b0}) >>> n5;
  assign rotVal  = (srcVal >> n5) | (srcVal << ((ShW+1)'(OpW) - {1'b0, n5}));

  always_comb begin
    resNext   = srcVal;
    carryNext = carryIn;
    if (!strb.isZero) begin
      unique case (strb.kind)
        KIND_SHL: begin
          if (strb.isExact)     begin resNext = '0; carryNext = srcVal[0]; end
          else if (strb.isOver) begin resNext = '0; carryNext = 1'b0; end
          else begin resNext = shlWide[OpW-1:0]; carryNext = shlWide[OpW]; end
        end
        KIND_SHR: begin
          if (strb.isExact)     begin resNext = '0; carryNext = srcVal[OpW-1]; end
          else if (strb.isOver) begin resNext = '0; carryNext = 1'b0; end
          else begin resNext = shrWide[OpW:1]; carryNext = shrWide[0]; end
        end
        KIND_SAR: begin
          if (strb.isExact || strb.isOver) begin
            resNext   = {OpW{srcVal[OpW-1]}};
            carryNext = srcVal[OpW-1];
          end else begin
            resNext   = sarWide[OpW:1];
            carryNext = sarWide[0];
          end
        end
        default: begin
          resNext   = rotVal;
          carryNext = rotVal[OpW-1];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      operandOut <= '0;
      carryOut   <= 1'b0;
      primed     <= 1'b0;
    end else begin
      operandOut <= resNext;
      carryOut   <= carryNext;
      primed     <= 1'b1;
    end
  end

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(strb.isZero) |-> operandOut == $past(srcVal) && carryOut == $past(carryIn)); // R8
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(strb.kind == KIND_ROT) |-> $countones(operandOut) == $countones($past(srcVal))); // R7
  AST_IMM_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(strb.useImm) |-> $countones(operandOut) == $countones($past(imm8))); // R2
  AST_SHR_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(strb.kind == KIND_SHR && !strb.isZero) |-> !operandOut[OpW-1]); // R6
  AST_SHL_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(strb.kind == KIND_SHL && strb.isOver && !strb.useImm) |-> operandOut == '0 && !carryOut); // R9
  AST_SAR_OVER_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(strb.kind == KIND_SAR && (strb.isOver || strb.isExact)) |->
      operandOut == {OpW{$past(srcVal[OpW-1])}}); // R10
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              immSel,
  input  logic [FieldW-1:0] src2Field,
  input  logic [OpW-1:0]    rmValue,
  input  logic [OpW-1:0]    rsValue,
  input  logic              carryIn,
  output logic [OpW-1:0]    operandOut,
  output logic              carryOut
);
  shiftStrobes_t strb;

  opnd_shifter_ctrl u_ctrl (
    .immSel    (immSel),
    .src2Field (src2Field),
    .rsLowByte (rsValue[AmtW-1:0]),
    .strb      (strb)
  );

  opnd_shifter_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .imm8       (src2Field[ImmW-1:0]),
    .rmValue    (rmValue),
    .carryIn    (carryIn),
    .operandOut (operandOut),
    .carryOut   (carryOut)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> operandOut == '0 && !carryOut); // R1
endmodule

// File: tb/opnd_shifter_test.sv
`timescale 1ns/1ps
module opnd_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        immSel = 1'b0;
  logic [11:0] src2Field = '0;
  logic [31:0] rmValue = '0;
  logic [31:0] rsValue = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operandOut;
  logic        carryOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  opnd_shifter uut (
    .clk(clk), .rst_n(rst_n), .immSel(immSel), .src2Field(src2Field),
    .rmValue(rmValue), .rsValue(rsValue), .carryIn(carryIn),
    .operandOut(operandOut), .carryOut(carryOut)
  );

  // Bench model: one bit per step, carry is the last bit pushed out.
  function automatic logic [32:0] model(input logic im, input logic [11:0] f,
                                        input logic [31:0] rm, input logic [31:0] rs,
                                        input logic ci);
    logic [31:0] v;
    logic [1:0]  k;
    int          n;
    logic        c;
    c = ci;
    if (im) begin
      v = {24'h0, f[7:0]};
      k = 2'b11;
      n = 2 * int'(f[11:8]);
    end else begin
      v = rm;
      k = f[6:5];
      n = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10:   begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0];  v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic compare(input string tag, input logic [31:0] expOp, input logic expC);
    nChecks++;
    if (operandOut !== expOp || carryOut !== expC) begin
      nFails++;
      $display("FAIL %s: got op=%08h c=%0b, expected op=%08h c=%0b",
               tag, operandOut, carryOut, expOp, expC);
    end
  endtask

  task automatic apply(input string tag, input logic im, input logic [11:0] f,
                       input logic [31:0] rm, input logic [31:0] rs, input logic ci);
    logic [32:0] e;
    @(negedge clk);
    immSel = im; src2Field = f; rmValue = rm; rsValue = rs; carryIn = ci;
    e = model(im, f, rm, rs, ci);
    @(negedge clk);
    compare(tag, e[31:0], e[32]);
  endtask

  // register form, amount from rs low byte
  function automatic logic [11:0] regAmt(input logic [1:0] k, input logic [3:0] rmIdx);
    return {4'h0, 1'b0, k, 1'b1, rmIdx};
  endfunction

  function automatic logic [11:0] fieldAmt(input logic [4:0] sh, input logic [1:0] k);
    return {sh, k, 1'b0, 4'h5};
  endfunction

  initial begin
    void'($urandom(32'd1640));
    immSel = 1'b1; src2Field = 12'hEFF; rmValue = 32'hFFFF_FFFF; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset", 32'h0, 1'b0);
    rst_n = 1'b1;

    apply("R2 imm 0xFF rot14", 1'b1, 12'hEFF, 32'h0, 32'h0, 1'b1);
    compare("R2 imm 0xFF rot14 literal", 32'h0000_0FF0, 1'b0);
    apply("R3 imm rot1 carry", 1'b1, 12'h13F, 32'h0, 32'h0, 1'b0);
    compare("R3 imm rot1 literal", 32'hC000_000F, 1'b1);
    apply("R3 imm rot0 keeps carry", 1'b1, 12'h0AA, 32'h0, 32'h0, 1'b1);
    compare("R3 imm rot0 literal", 32'h0000_00AA, 1'b1);
    apply("R5 LSL 4", 1'b0, fieldAmt(5'd4, 2'b00), 32'h1234_5678, 32'h0, 1'b0);
    compare("R5 LSL 4 literal", 32'h2345_6780, 1'b1);
    apply("R6 LSR 2", 1'b0, fieldAmt(5'd2, 2'b01), 32'h8000_0007, 32'h0, 1'b0);
    compare("R6 LSR 2 literal", 32'h2000_0001, 1'b1);
    apply("R6 ASR 4", 1'b0, fieldAmt(5'd4, 2'b10), 32'h8000_0010, 32'h0, 1'b1);
    compare("R6 ASR 4 literal", 32'hF800_0001, 1'b0);
    apply("R7 ROR 8", 1'b0, fieldAmt(5'd8, 2'b11), 32'h1122_3381, 32'h0, 1'b0);
    compare("R7 ROR 8 literal", 32'h8111_2233, 1'b1);
    apply("R7 ROR 64 by reg", 1'b0, regAmt(2'b11, 4'h2), 32'h8000_0001, 32'h40, 1'b0);
    compare("R7 ROR 64 literal", 32'h8000_0001, 1'b1);
    apply("R8 zero field amount", 1'b0, fieldAmt(5'd0, 2'b10), 32'hDEAD_BEEF, 32'h0, 1'b1);
    compare("R8 zero literal", 32'hDEAD_BEEF, 1'b1);
    apply("R8 R11 zero reg amount junk upper", 1'b0, regAmt(2'b00, 4'h1), 32'hCAFE_0001, 32'h1234_5600, 1'b0);
    compare("R8 R11 zero reg literal", 32'hCAFE_0001, 1'b0);
    apply("R9 LSL 32", 1'b0, regAmt(2'b00, 4'h0), 32'h0000_0001, 32'h20, 1'b0);
    compare("R9 LSL 32 literal", 32'h0, 1'b1);
    apply("R9 LSR 32", 1'b0, regAmt(2'b01, 4'h0), 32'h8000_0000, 32'h20, 1'b0);
    compare("R9 LSR 32 literal", 32'h0, 1'b1);
    apply("R9 LSR 33", 1'b0, regAmt(2'b01, 4'h0), 32'hFFFF_FFFF, 32'h21, 1'b1);
    compare("R9 LSR 33 literal", 32'h0, 1'b0);
    apply("R9 LSL 255", 1'b0, regAmt(2'b00, 4'h0), 32'hFFFF_FFFF, 32'hFF, 1'b1);
    compare("R9 LSL 255 literal", 32'h0, 1'b0);
    apply("R10 ASR 200 neg", 1'b0, regAmt(2'b10, 4'h0), 32'h8000_1234, 32'hC8, 1'b0);
    compare("R10 ASR 200 literal", 32'hFFFF_FFFF, 1'b1);
    apply("R10 ASR 32 pos", 1'b0, regAmt(2'b10, 4'h0), 32'h7FFF_FFFF, 32'h20, 1'b1);
    compare("R10 ASR 32 literal", 32'h0, 1'b0);
    apply("R11 upper rs ignored", 1'b0, regAmt(2'b01, 4'h0), 32'hF0F0_F0F0, 32'hFFFF_FF04, 1'b0);
    compare("R11 upper rs literal", 32'h0F0F_0F0F, 1'b0);
    apply("R4 low nibble ignored", 1'b0, {5'd3, 2'b00, 1'b0, 4'hF}, 32'h0000_0011, 32'h0, 1'b0);
    compare("R4 low nibble literal", 32'h0000_0088, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic        im;
      logic [11:0] f;
      logic [31:0] rm, rs;
      string       tag;
      im = ($urandom % 4) == 0;
      f  = 12'($urandom);
      rm = $urandom;
      rs = $urandom;
      if (($urandom % 3) == 0) rs[7:0] = 8'(($urandom % 3) * 32 + ($urandom % 2));
      if (im) tag = "R2 R3 random imm";
      else begin
        case (f[6:5])
          2'b00:   tag = "R4 R5 random LSL";
          2'b01:   tag = "R4 R6 R9 random LSR";
          2'b10:   tag = "R4 R6 R10 random ASR";
          default: tag = "R4 R7 random ROR";
        endcase
      end
      apply(tag, im, f, rm, rs, 1'($urandom));
    end

    // R1 latency and reset re-entry
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); compare("R1 reset again", 32'h0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got cycles=%0d, expected under 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule